// File: doc/BRIEF.md
# SPI EEPROM word write sequencer

This block is the master side of a single-word write into a serial EEPROM on an SPI bus. A user-side request carries a word offset and a 16-bit data word. The sequencer rejects offsets that do not fit the configured device size without touching the bus. Otherwise it polls the device status until the device reports no write in progress. It then sends a write-enable frame and a write frame that holds the opcode, the byte address and the data word. After that it waits a programmable settle time and signals completion.

Every command goes out in SPI mode 0. SCK idles low, the device samples on the rising edge and MOSI changes on the falling edge. SCK is divided down from the system clock, and each SCK half period lasts `CLK_HALF` clock cycles. Between frames, chip select goes high for at least one full SCK period (`2*CLK_HALF` cycles). Two address formats are supported, selected by `cfg_wide_addr`. With 16-bit addressing the full byte address is sent. With 8-bit addressing the ninth byte-address bit moves into the write opcode.

States: `S_IDLE`, `S_POLL_OP`, `S_POLL_RD`, `S_POLL_GAP`, `S_WREN`, `S_WREN_GAP`, `S_WR_OP`, `S_WR_ADDR`, `S_WR_DATA`, `S_WR_GAP`, `S_SETTLE`, `S_DONE`, `S_FAIL`.

Transitions:
- `S_IDLE`: on `start`, goes to `S_FAIL` when the offset is out of range, otherwise to `S_POLL_OP`.
- Each shift state moves on at the last falling SCK edge of its field:
  - `S_POLL_OP` to `S_POLL_RD`, then to `S_POLL_GAP`.
  - `S_WREN` to `S_WREN_GAP`.
  - `S_WR_OP` to `S_WR_ADDR`, then to `S_WR_DATA`, then to `S_WR_GAP`.
- When the timer expires:
  - `S_POLL_GAP` goes to `S_WREN` if the device is idle. If it is still busy, it goes to `S_FAIL` once the poll limit is used up, and otherwise back to `S_POLL_OP`.
  - `S_WREN_GAP` goes to `S_WR_OP`.
  - `S_WR_GAP` goes to `S_SETTLE`, and `S_SETTLE` goes to `S_DONE`.
- `S_DONE` and `S_FAIL` return to `S_IDLE`.

Top module: `spi_eeprom_word_writer`

## Requirements
- R1: A start with `word_offset >= cfg_word_count` produces an `error` pulse in the cycle after the start is accepted, and chip select never goes low for that request.
- R2: The readiness check is one chip-select frame: opcode 0x05 (8 bits), then 8 read bits. Bit 0 of the byte read is the write-in-progress flag. While that flag is 1, the frame repeats after a standby.
- R3: If `POLL_LIMIT` status frames in a row all report write in progress, the request ends with `error`, and no write-enable or write frame is sent.
- R4: After a ready status, a frame holding only the write-enable opcode 0x06 (8 bits) is sent. Between any two frames of a request, chip select stays high for at least `2*CLK_HALF` cycles.
- R5: The write frame is opcode 0x02 followed by 16 address bits when `cfg_wide_addr`=1, or 8 address bits when it is 0, then 16 data bits: 40 or 32 bits in all.
- R6: With 8-bit addressing and a word offset of 128 or more, the write opcode becomes 0x0A (bit 3 set). For an offset of 127 or less it stays 0x02.
- R7: The address field carries the byte address, twice the word offset, cut to the address width.
- R8: The data field sends the low byte of the data word first, then the high byte, each byte MSB first.
- R9: `done` rises exactly `2*CLK_HALF + cfg_settle + 1` cycles after chip select goes high at the end of the write frame.
- R10: `busy` is high from the cycle after an accepted start up to and including the single-cycle `done` or `error` pulse. It is low in the cycle after that pulse. `done` and `error` never coincide.
- R11: A `start` while `busy` is high is ignored: the bus traffic and the result belong to the first request only, and no second completion follows.
- R12: SCK is low whenever chip select is high, and MOSI does not change while SCK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted while not busy |
| word_offset | input | 16 | Word offset to write |
| word_data | input | 16 | Data word to write |
| cfg_wide_addr | input | 1 | 1: 16-bit address field, 0: 8-bit address field |
| cfg_word_count | input | 16 | Device size in 16-bit words |
| cfg_settle | input | SETTLE_W | Settle delay in cycles after the write frame |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| error | output | 1 | One-cycle pulse on range or readiness failure |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The hardest path to reach from the ports is the readiness timeout. It needs a device that keeps answering "write in progress" over several whole status frames. The bench contains a small behavioural device that serves a status byte on MISO, with a per-test count of busy replies. Setting that count at or above `POLL_LIMIT` drives the sequencer into `S_FAIL` after polling. Setting it just below the limit covers the last poll that still succeeds. The fold of the ninth address bit is reached by offsets on both sides of 128 with 8-bit addressing.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL_OP,
        S_POLL_RD,
        S_POLL_GAP,
        S_WREN,
        S_WREN_GAP,
        S_WR_OP,
        S_WR_ADDR,
        S_WR_DATA,
        S_WR_GAP,
        S_SETTLE,
        S_DONE,
        S_FAIL
    } spiw_state_e;

    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_A8    = 8'h08;

    localparam int SEG_W = 16;

endpackage

// File: rtl/spiw_shifter.sv
module spiw_shifter #(
    parameter int CLK_HALF = 2,
    parameter int SEG_W    = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       seg_start,
    input  logic [$clog2(SEG_W+1)-1:0] seg_len,
    input  logic [SEG_W-1:0]           seg_din,
    input  logic                       spi_miso,
    output logic                       seg_last,
    output logic                       seg_rx_bit,
    output logic                       spi_sck,
    output logic                       spi_mosi
);
    localparam int LEN_W = $clog2(SEG_W + 1);
    localparam int DIV_W = $clog2(CLK_HALF + 1);

    logic [SEG_W-1:0] sh_q;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    logic             act_q;
    logic             sck_q;
    logic             rxb_q;
    logic             tick;

    assign tick       = act_q && (div_q == DIV_W'(CLK_HALF - 1));
    assign seg_last   = tick && sck_q && (cnt_q == len_q - 1'b1);
    assign seg_rx_bit = rxb_q;
    assign spi_sck    = sck_q;
    assign spi_mosi   = act_q & sh_q[SEG_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            len_q <= '0;
            cnt_q <= '0;
            div_q <= '0;
            act_q <= 1'b0;
            sck_q <= 1'b0;
            rxb_q <= 1'b0;
        end else if (seg_start) begin
            sh_q  <= seg_din << (LEN_W'(SEG_W) - seg_len);
            len_q <= seg_len;
            cnt_q <= '0;
            div_q <= '0;
            sck_q <= 1'b0;
            act_q <= 1'b1;
        end else if (act_q) begin
            if (tick) begin
                div_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rxb_q <= spi_miso;
                end else begin
                    sck_q <= 1'b0;
                    sh_q  <= {sh_q[SEG_W-2:0], 1'b0};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == len_q - 1'b1) begin
                        act_q <= 1'b0;
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/spiw_delay.sv
module spiw_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    assign expired = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/spi_eeprom_word_writer.sv
module spi_eeprom_word_writer
    import spiw_pkg::*;
#(
    parameter int CLK_HALF   = 2,
    parameter int POLL_LIMIT = 3,
    parameter int SETTLE_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [15:0]         word_offset,
    input  logic [15:0]         word_data,
    input  logic                cfg_wide_addr,
    input  logic [15:0]         cfg_word_count,
    input  logic [SETTLE_W-1:0] cfg_settle,
    output logic                busy,
    output logic                done,
    output logic                error,
    output logic                spi_cs_n,
    output logic                spi_sck,
    output logic                spi_mosi,
    input  logic                spi_miso
);
    localparam int GAP_CYC = 2 * CLK_HALF;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);
    localparam int TMR_W   = (SETTLE_W > GAP_W) ? SETTLE_W : GAP_W;
    localparam int POLL_W  = $clog2(POLL_LIMIT + 1);
    localparam int LEN_W   = $clog2(SEG_W + 1);

    spiw_state_e st_q, nx;

    logic [15:0]       off_q;
    logic [15:0]       dat_q;
    logic              wide_q;
    logic              wip_q;
    logic [POLL_W-1:0] polls_q;

    logic              sh_start;
    logic [LEN_W-1:0]  sh_len;
    logic [SEG_W-1:0]  sh_din;
    logic              sh_last;
    logic              sh_rxb;

    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_zero;

    logic [15:0]       byte_addr;
    logic [7:0]        wr_opcode;

    function automatic logic is_shift(spiw_state_e s);
        return (s == S_POLL_OP) || (s == S_POLL_RD) || (s == S_WREN) ||
               (s == S_WR_OP) || (s == S_WR_ADDR) || (s == S_WR_DATA);
    endfunction

    assign byte_addr = {off_q[14:0], 1'b0};
    assign wr_opcode = OP_WRITE | ((!wide_q && off_q >= 16'd128) ? OP_A8 : 8'h00);

    spiw_shifter #(
        .CLK_HALF (CLK_HALF),
        .SEG_W    (SEG_W)
    ) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .seg_start  (sh_start),
        .seg_len    (sh_len),
        .seg_din    (sh_din),
        .spi_miso   (spi_miso),
        .seg_last   (sh_last),
        .seg_rx_bit (sh_rxb),
        .spi_sck    (spi_sck),
        .spi_mosi   (spi_mosi)
    );

    spiw_delay #(
        .W (TMR_W)
    ) u_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    // next-state decision
    always_comb begin
        nx = st_q;
        unique case (st_q)
            S_IDLE:     if (start) nx = (word_offset >= cfg_word_count) ? S_FAIL : S_POLL_OP;
            S_POLL_OP:  if (sh_last) nx = S_POLL_RD;
            S_POLL_RD:  if (sh_last) nx = S_POLL_GAP;
            S_POLL_GAP: if (tmr_zero) begin
                            if (!wip_q)                                 nx = S_WREN;
                            else if (polls_q >= POLL_W'(POLL_LIMIT))    nx = S_FAIL;
                            else                                        nx = S_POLL_OP;
                        end
            S_WREN:     if (sh_last) nx = S_WREN_GAP;
            S_WREN_GAP: if (tmr_zero) nx = S_WR_OP;
            S_WR_OP:    if (sh_last) nx = S_WR_ADDR;
            S_WR_ADDR:  if (sh_last) nx = S_WR_DATA;
            S_WR_DATA:  if (sh_last) nx = S_WR_GAP;
            S_WR_GAP:   if (tmr_zero) nx = S_SETTLE;
            S_SETTLE:   if (tmr_zero) nx = S_DONE;
            S_DONE:     nx = S_IDLE;
            S_FAIL:     nx = S_IDLE;
            default:    nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= nx;
        end
    end

    // request capture and poll bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q   <= '0;
            dat_q   <= '0;
            wide_q  <= 1'b0;
            wip_q   <= 1'b0;
            polls_q <= '0;
        end else begin
            if (st_q == S_IDLE && start) begin
                off_q   <= word_offset;
                dat_q   <= word_data;
                wide_q  <= cfg_wide_addr;
                polls_q <= '0;
            end
            if (st_q == S_POLL_RD && sh_last) begin
                wip_q   <= sh_rxb;
                polls_q <= polls_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        busy     = (st_q != S_IDLE);
        done     = (st_q == S_DONE);
        error    = (st_q == S_FAIL);
        spi_cs_n = !is_shift(st_q);

        sh_start = (nx != st_q) && is_shift(nx);
        tmr_load = (nx != st_q) &&
                   (nx == S_POLL_GAP || nx == S_WREN_GAP || nx == S_WR_GAP || nx == S_SETTLE);
        tmr_val  = (nx == S_SETTLE) ? TMR_W'(cfg_settle) : TMR_W'(GAP_CYC - 1);

        sh_len = LEN_W'(8);
        sh_din = '0;
        unique case (nx)
            S_POLL_OP: sh_din = {8'h00, OP_RDSR};
            S_WREN:    sh_din = {8'h00, OP_WREN};
            S_WR_OP:   sh_din = {8'h00, wr_opcode};
            S_WR_ADDR: begin
                sh_len = wide_q ? LEN_W'(16) : LEN_W'(8);
                sh_din = wide_q ? byte_addr : {8'h00, byte_addr[7:0]};
            end
            S_WR_DATA: begin
                sh_len = LEN_W'(16);
                sh_din = {dat_q[7:0], dat_q[15:8]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spiw_checker.sv
module spiw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [15:0] word_offset,
    input logic [15:0] cfg_word_count,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic        spi_cs_n,
    input logic        spi_sck,
    input logic        spi_mosi
);

    p_range_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && word_offset >= cfg_word_count) |=> (error && spi_cs_n));

    p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done || error));

    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    p_pulse_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> busy);

    p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    p_sck_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    p_mosi_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

endmodule

bind spi_eeprom_word_writer spiw_checker u_spiw_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .word_offset    (word_offset),
    .cfg_word_count (cfg_word_count),
    .busy           (busy),
    .done           (done),
    .error          (error),
    .spi_cs_n       (spi_cs_n),
    .spi_sck        (spi_sck),
    .spi_mosi       (spi_mosi)
);

// File: tb/tb_spi_eeprom_word_writer.sv
`timescale 1ns/1ps
module tb_spi_eeprom_word_writer;
    localparam int CLK_HALF   = 2;
    localparam int POLL_LIMIT = 3;
    localparam int SETTLE_W   = 8;
    localparam int NV         = 9;

    // {wide, offset, data, word_count, busy_replies, settle}
    localparam logic [60:0] VEC [NV] = '{
        {1'b1, 16'h0123, 16'hA55A, 16'h1000, 4'd0, 8'd3},
        {1'b1, 16'h0FFF, 16'h1234, 16'h1000, 4'd2, 8'd0},
        {1'b0, 16'h0010, 16'hBEEF, 16'h0100, 4'd1, 8'd5},
        {1'b0, 16'h0090, 16'h00FF, 16'h0100, 4'd0, 8'd1},
        {1'b0, 16'h0080, 16'h8001, 16'h0100, 4'd0, 8'd2},
        {1'b0, 16'h007F, 16'hC33C, 16'h0100, 4'd0, 8'd0},
        {1'b1, 16'h1000, 16'h5555, 16'h1000, 4'd0, 8'd1},
        {1'b1, 16'h0002, 16'h6789, 16'h1000, 4'd3, 8'd1},
        {1'b0, 16'h00FF, 16'hF00D, 16'h0100, 4'd5, 8'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [15:0] word_offset = '0;
    logic [15:0] word_data = '0;
    logic cfg_wide_addr = 1'b0;
    logic [15:0] cfg_word_count = '0;
    logic [SETTLE_W-1:0] cfg_settle = '0;
    logic busy, done, error, spi_cs_n, spi_sck, spi_mosi, spi_miso;

    always #2 clk = ~clk;

    spi_eeprom_word_writer #(
        .CLK_HALF   (CLK_HALF),
        .POLL_LIMIT (POLL_LIMIT),
        .SETTLE_W   (SETTLE_W)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .word_offset    (word_offset),
        .word_data      (word_data),
        .cfg_wide_addr  (cfg_wide_addr),
        .cfg_word_count (cfg_word_count),
        .cfg_settle     (cfg_settle),
        .busy           (busy),
        .done           (done),
        .error          (error),
        .spi_cs_n       (spi_cs_n),
        .spi_sck        (spi_sck),
        .spi_mosi       (spi_mosi),
        .spi_miso       (spi_miso)
    );

    // behavioural device: frame logger and status responder
    logic [63:0] flog [128];
    int          flen [128];
    int          fgap [128];
    logic [63:0] fbits = '0;
    int          fcnt = 0;
    int          nf = 0;
    int          rd_total = 0;
    int          rd_base = 0;
    int          bp_cur = 0;
    int          hi_cnt = 0;
    logic [7:0]  stat_now;

    assign stat_now = ((rd_total - rd_base) < bp_cur) ? 8'h01 : 8'h00;
    assign spi_miso = (!spi_cs_n && fcnt >= 8 && fcnt < 16) ? stat_now[3'(15 - fcnt)] : 1'b0;

    always @(posedge spi_sck or posedge spi_cs_n) begin
        if (spi_cs_n) begin
            if (fcnt > 0) begin
                flog[nf] <= fbits;
                flen[nf] <= fcnt;
                nf <= nf + 1;
                if (fcnt == 16 && fbits[15:8] == 8'h05) rd_total <= rd_total + 1;
            end
            fcnt  <= 0;
            fbits <= '0;
        end else begin
            fbits <= {fbits[62:0], spi_mosi};
            fcnt  <= fcnt + 1;
        end
    end

    always @(negedge clk) hi_cnt <= spi_cs_n ? hi_cnt + 1 : 0;
    always @(negedge spi_cs_n) fgap[nf] = hi_cnt;

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [60:0] v, input bit inj);
        logic        wide;
        logic [15:0] off, dat, wc;
        int          bp, stl, base, exp_rd, exp_nf, scnt, idle_bad, wi;
        bit          rerr, tout, ok, got_d, got_e, fold;
        logic [7:0]  e_op, a_op;
        logic [15:0] e_addr, a_addr, a_dat, e_dat;
        int          e_len, min_gap;
        {wide, off, dat, wc} = v[60:12];
        bp  = int'(v[11:8]);
        stl = int'(v[7:0]);
        rerr = (off >= wc);
        tout = !rerr && (bp >= POLL_LIMIT);
        ok   = !rerr && !tout;
        exp_rd = rerr ? 0 : (tout ? POLL_LIMIT : bp + 1);
        exp_nf = exp_rd + (ok ? 2 : 0);
        fold   = !wide && (off >= 16'd128);
        e_op   = fold ? 8'h0A : 8'h02;
        e_addr = wide ? {off[14:0], 1'b0} : {8'h00, off[6:0], 1'b0};
        e_dat  = {dat[7:0], dat[15:8]};
        e_len  = wide ? 40 : 32;

        base = nf; rd_base = rd_total; bp_cur = bp;
        @(negedge clk);
        word_offset = off; word_data = dat; cfg_wide_addr = wide;
        cfg_word_count = wc; cfg_settle = SETTLE_W'(stl); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accept", 64'(busy), 1);
        got_d = 0; got_e = 0; scnt = 0; idle_bad = 0;
        for (int k = 0; k < 4000; k++) begin
            if (k > 0) @(negedge clk);
            if (inj && k == 40) begin word_offset = 16'h0001; word_data = 16'hFFFF; start = 1'b1; end
            if (inj && k == 41) start = 1'b0;
            if (spi_cs_n && spi_sck) idle_bad++;
            if (done || error) begin got_d = done; got_e = error; break; end
            if (ok && nf == base + exp_nf) scnt++;
        end
        start = 1'b0;
        chk(got_e == !ok, rerr ? "R1" : "R3", "error outcome", 64'(got_e), 64'(!ok));
        chk(got_d == ok, "R10", "done outcome", 64'(got_d), 64'(ok));
        chk(nf - base == exp_nf, rerr ? "R1" : (tout ? "R3" : "R2"), "frame count",
            64'(nf - base), 64'(exp_nf));
        if (nf - base == exp_nf) begin
            for (int i = 0; i < exp_rd; i++)
                chk(flen[base+i] == 16 && flog[base+i][15:8] == 8'h05, "R2", "status frame",
                    flog[base+i], 64'h0500);
            if (ok) begin
                chk(flen[base+exp_rd] == 8 && flog[base+exp_rd][7:0] == 8'h06, "R4",
                    "write-enable frame", flog[base+exp_rd], 64'h06);
                wi = base + exp_rd + 1;
                chk(flen[wi] == e_len, "R5", "write frame length", 64'(flen[wi]), 64'(e_len));
                a_op   = wide ? flog[wi][39:32] : flog[wi][31:24];
                a_addr = wide ? flog[wi][31:16] : {8'h00, flog[wi][23:16]};
                a_dat  = flog[wi][15:0];
                chk(a_op == e_op, fold ? "R6" : "R5", "write opcode", 64'(a_op), 64'(e_op));
                chk(a_addr == e_addr, "R7", "byte address", 64'(a_addr), 64'(e_addr));
                chk(a_dat == e_dat, "R8", "swapped data", 64'(a_dat), 64'(e_dat));
                chk(scnt == 2*CLK_HALF + stl + 1, "R9", "settle cycles", 64'(scnt),
                    64'(2*CLK_HALF + stl + 1));
            end
            min_gap = 1000;
            for (int i = 1; i < exp_nf; i++) if (fgap[base+i] < min_gap) min_gap = fgap[base+i];
            if (exp_nf > 1)
                chk(min_gap >= 2*CLK_HALF, "R4", "standby gap", 64'(min_gap), 64'(2*CLK_HALF));
        end
        chk(idle_bad == 0, "R12", "sck idle while deselected", 64'(idle_bad), 0);
        @(negedge clk);
        chk(!busy && !done && !error, "R10", "idle after pulse", {61'd0, busy, done, error}, 0);
        if (inj) begin
            repeat (30) @(negedge clk);
            chk(nf - base == exp_nf && !busy && !done, "R11", "no second request",
                64'(nf - base), 64'(exp_nf));
        end
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        $display("FAIL watchdog R10: actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(spi_cs_n && !spi_sck && !busy && !done && !error, "R10", "reset state",
            {59'd0, spi_cs_n, spi_sck, busy, done, error}, 64'h10);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NV; i++) run(VEC[i], 1'b0);
        run(VEC[0], 1'b1);
        run(VEC[3], 1'b1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule